// File: doc/BRIEF.md
# Fourth-Order Sinc Decimation Filter

This block turns the single-bit output of a delta-sigma modulator into signed 16-bit samples. Every accepted modulator bit counts as +1 or -1. The block runs the bit through a cascade of four integrators. At each decimation instant it takes a cascade of four differentiators. The result is a (sin x / x)^4 response whose -3 dB corner sits near a quarter of the output word rate. The decimation ratio `DECIM` is a power-of-two parameter of at least 16. Its default is 2048, and 16384 is the other intended setting. The filter state is as wide as the worst-case gain needs, and its arithmetic wraps.

A conversion begins with a start pulse. The mode select is captured at that moment. In single-cycle mode the block produces exactly one word, after four full decimation periods. It then clears all of its state and ignores the modulator until the next start. In continuous mode the state is never cleared. Once the filter has settled, a word appears at the end of every decimation period. The raw sum is scaled down by an arithmetic shift and clamped to the 16-bit range, so a stream of all ones reads as positive full scale and a stream of all zeros as negative full scale.

Top module: `sinc4_decimator`

## Requirements
- R1: While reset (rstN low) is held and after it is released, validOut is 0 and resultWord is 0 until the first result word.
- R2: A startPulse clears every integrator and differentiator and begins a new conversion. A modulator bit offered in the same cycle as startPulse is discarded.
- R3: A bit is accepted only when sampleEn is high and a conversion is active. Bit value 1 counts as +1 and bit value 0 counts as -1.
- R4: After n accepted bits, with n a multiple of DECIM, the raw result is the moving sum of length DECIM applied four times over the accepted values. Values before the start count as zero.
- R5: resultWord is the raw result shifted right arithmetically by 4*log2(DECIM)-15 bits and then clamped to -32768..32767. An all-ones conversion gives 32767 and an all-zeros conversion gives -32768.
- R6: In single-cycle mode (modeCont=0 at start) exactly one word is produced, after 4*DECIM accepted bits. After that, bits are ignored and resultWord holds its value until the next start.
- R7: In continuous mode (modeCont=1 at start) a word is produced after every DECIM-th accepted bit, from the 4*DECIM-th onward, and state is never cleared between words.
- R8: validOut is a one-cycle pulse. It rises on the clock edge after the edge that accepts the completing bit, together with the new resultWord. Between pulses, resultWord holds its value.
- R9: A startPulse during a conversion aborts it. The result then depends only on bits accepted after the new start.
- R10: The mode is captured at startPulse. Changes of modeCont during a conversion have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sampleEn | input | 1 | Modulator-rate enable; modBit is valid when high |
| modBit | input | 1 | Modulator output bit (1 = +1, 0 = -1) |
| modeCont | input | 1 | Mode select captured at start: 0 single-cycle, 1 continuous |
| startPulse | input | 1 | Begins a new conversion and clears the filter |
| resultWord | output | 16 | Signed two's complement result |
| validOut | output | 1 | One-cycle strobe marking a new resultWord |

## Verification
A corrupted integrator or differentiator leaves a persistent error in every later word. In continuous mode that error is visible at the first settled output, 4*DECIM accepted bits after start. A state clear that fails at the end of a single-cycle conversion shows up in the very next conversion's only word. A miscount in the sample or period counters moves or adds validOut pulses, which a per-cycle strobe comparison catches within one decimation period. The sums are compared against an independent convolution with the fourth-order box kernel, under random enable gaps, biased random streams, and all-ones and all-zeros extremes.

// File: rtl/sinc4_pkg.sv
package sinc4_pkg;

  // Strobes from control to datapath, one cycle each
  typedef struct packed {
    logic clr;   // zero all filter state
    logic step;  // accept the current modulator bit
    logic dump;  // decimation instant: advance the differentiators
    logic emit;  // publish the scaled result
  } sinc4_strobe_t;

endpackage

// File: rtl/sinc4_ctrl.sv
module sinc4_ctrl
  import sinc4_pkg::*;
#(
  parameter int DECIM = 2048
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          sampleEn,
  input  logic          modeCont,
  input  logic          startPulse,
  output sinc4_strobe_t strobe
);

  localparam int LOG2 = $clog2(DECIM);
  localparam logic [LOG2-1:0] LAST_IDX = LOG2'(DECIM - 1);
  localparam logic [2:0] SETTLED = 3'd4;

  logic            running;
  logic            modeReg;
  logic [LOG2-1:0] sampleCnt;
  logic [2:0]      periodCnt;
  logic            accept;
  logic            lastSample;
  logic            finish;

  always_comb begin
    accept      = running && sampleEn && !startPulse;
    lastSample  = accept && (sampleCnt == LAST_IDX);
    strobe.step = accept;
    strobe.dump = lastSample;
    strobe.emit = lastSample && (periodCnt >= 3'd3);
    finish      = strobe.emit && !modeReg;
    strobe.clr  = startPulse || finish;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      running   <= 1'b0;
      modeReg   <= 1'b0;
      sampleCnt <= '0;
      periodCnt <= '0;
    end else if (startPulse) begin
      running   <= 1'b1;
      modeReg   <= modeCont;
      sampleCnt <= '0;
      periodCnt <= '0;
    end else begin
      if (accept) sampleCnt <= sampleCnt + 1'b1;
      if (lastSample && periodCnt != SETTLED) periodCnt <= periodCnt + 3'd1;
      if (finish) running <= 1'b0;
    end
  end

  AST_SINGLE_STOPS: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.emit && !modeReg && !startPulse) |=> !running); // R6
  AST_START_ARMS: assert property (@(posedge clk) disable iff (!rstN)
    startPulse |=> (running && sampleCnt == '0 && periodCnt == '0)); // R9
  AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (running && !startPulse) |=> $stable(modeReg)); // R10

endmodule

// File: rtl/sinc4_datapath.sv
module sinc4_datapath
  import sinc4_pkg::*;
#(
  parameter int DECIM = 2048
) (
  input  logic          clk,
  input  logic          rstN,
  input  sinc4_strobe_t strobe,
  input  logic          modBit,
  output logic [15:0]   resultWord,
  output logic          validOut
);

  localparam int LOG2   = $clog2(DECIM);
  localparam int W      = 4 * LOG2 + 2;
  localparam int SHIFT  = 4 * LOG2 - 15;
  localparam int STAGES = 4;

  typedef logic signed [W-1:0] acc_t;

  acc_t integ   [STAGES];
  acc_t combDly [STAGES];
  acc_t sVal;
  acc_t i0n, i1n, i2n, i3n;
  acc_t c1, c2, c3, c4;
  acc_t combIn  [STAGES];
  acc_t scaled;
  logic [15:0] satVal;

  // Integrator cascade, all four stages in one cycle
  always_comb begin
    sVal = modBit ? acc_t'(1) : acc_t'(-1);
    i0n  = integ[0] + sVal;
    i1n  = integ[1] + i0n;
    i2n  = integ[2] + i1n;
    i3n  = integ[3] + i2n;
  end

  // Differentiator cascade on the decimated value
  always_comb begin
    c1 = i3n - combDly[0];
    c2 = c1  - combDly[1];
    c3 = c2  - combDly[2];
    c4 = c3  - combDly[3];
    combIn[0] = i3n;
    combIn[1] = c1;
    combIn[2] = c2;
    combIn[3] = c3;
  end

  // Scale and clamp
  always_comb begin
    scaled = c4 >>> SHIFT;
    if (scaled > acc_t'(32767))       satVal = 16'h7FFF;
    else if (scaled < acc_t'(-32768)) satVal = 16'h8000;
    else                              satVal = scaled[15:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int k = 0; k < STAGES; k++) begin
        integ[k]   <= '0;
        combDly[k] <= '0;
      end
    end else if (strobe.clr) begin
      for (int k = 0; k < STAGES; k++) begin
        integ[k]   <= '0;
        combDly[k] <= '0;
      end
    end else if (strobe.step) begin
      integ[0] <= i0n;
      integ[1] <= i1n;
      integ[2] <= i2n;
      integ[3] <= i3n;
      if (strobe.dump) begin
        for (int k = 0; k < STAGES; k++) combDly[k] <= combIn[k];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resultWord <= '0;
      validOut   <= 1'b0;
    end else begin
      validOut <= strobe.emit;
      if (strobe.emit) resultWord <= satVal;
    end
  end

  AST_CLEAR_STATE: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clr |=> (integ[0] == '0 && integ[3] == '0 && combDly[0] == '0 && combDly[3] == '0)); // R2
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.step && !strobe.clr) |=> $stable(integ[3])); // R3
  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    validOut |=> !validOut); // R8
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.emit |=> $stable(resultWord)); // R8

endmodule

// File: rtl/sinc4_decimator.sv
module sinc4_decimator
  import sinc4_pkg::*;
#(
  parameter int DECIM = 2048
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        sampleEn,
  input  logic        modBit,
  input  logic        modeCont,
  input  logic        startPulse,
  output logic [15:0] resultWord,
  output logic        validOut
);

  sinc4_strobe_t strobe;

  sinc4_ctrl #(.DECIM(DECIM)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .sampleEn   (sampleEn),
    .modeCont   (modeCont),
    .startPulse (startPulse),
    .strobe     (strobe)
  );

  sinc4_datapath #(.DECIM(DECIM)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .modBit     (modBit),
    .resultWord (resultWord),
    .validOut   (validOut)
  );

endmodule

// File: tb/sinc4_decimator_tb.sv
`timescale 1ns/1ps
module sinc4_decimator_tb;

  localparam int R     = 64;
  localparam int LOG2  = 6;
  localparam int SHIFT = 4 * LOG2 - 15;
  localparam int KLEN  = 4 * R - 3;
  localparam int MAXH  = 4096;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        sampleEn = 1'b0;
  logic        modBit = 1'b0;
  logic        modeCont = 1'b0;
  logic        startPulse = 1'b0;
  logic [15:0] resultWord;
  logic        validOut;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  longint kern [4*R];
  int     hist [MAXH];
  int     nAcc = 0;
  bit     active = 0;
  bit     convCont = 0;
  string  curTag = "R4";
  int     validCount = 0;

  always #10 clk = ~clk;

  sinc4_decimator #(.DECIM(R)) u_dut (
    .clk(clk), .rstN(rstN), .sampleEn(sampleEn), .modBit(modBit),
    .modeCont(modeCont), .startPulse(startPulse),
    .resultWord(resultWord), .validOut(validOut)
  );

  // Fourth-order box kernel
  function automatic void buildKernel();
    longint tmp [4*R];
    int len = R;
    for (int j = 0; j < 4*R; j++) kern[j] = (j < R) ? 1 : 0;
    for (int m = 1; m < 4; m++) begin
      for (int j = 0; j < 4*R; j++) tmp[j] = 0;
      for (int j = 0; j < len; j++)
        for (int q = 0; q < R; q++) tmp[j+q] += kern[j];
      len = len + R - 1;
      for (int j = 0; j < 4*R; j++) kern[j] = tmp[j];
    end
  endfunction

  function automatic int expected(int n);
    longint y = 0;
    longint s;
    for (int j = 0; j < KLEN && j < n; j++) y += kern[j] * hist[n-1-j];
    s = y >>> SHIFT;
    if (s > 32767) s = 32767;
    if (s < -32768) s = -32768;
    return int'(s);
  endfunction

  task automatic checkVal(string tag, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Drive one cycle at negedge, check outputs at the next negedge
  task automatic stepCycle(bit en, bit b);
    bit expV = 0;
    sampleEn = en;
    modBit = b;
    @(negedge clk);
    if (en && active && nAcc < MAXH) begin
      hist[nAcc] = b ? 1 : -1;
      nAcc++;
      if (nAcc % R == 0 && nAcc >= 4*R) begin
        expV = 1;
        if (!convCont) active = 0;
      end
    end
    if (validOut !== expV) begin
      tests++;
      fails++;
      $display("FAIL R8: validOut actual=%0d expected=%0d", validOut, expV);
    end
    if (expV) begin
      validCount++;
      checkVal(curTag, int'($signed(resultWord)), expected(nAcc));
    end
  endtask

  task automatic startConv(bit cont, bit en, bit b);
    startPulse = 1'b1;
    modeCont = cont;
    sampleEn = en;
    modBit = b;
    @(negedge clk);
    startPulse = 1'b0;
    nAcc = 0;
    active = 1;
    convCont = cont;
    validCount = 0;
  endtask

  // pattern: 0 ones, 1 zeros, 2 alternating, 3 biased random
  function automatic bit genBit(int pattern, int idx, int pct);
    case (pattern)
      0: return 1'b1;
      1: return 1'b0;
      2: return idx[0];
      default: return (($urandom % 100) < pct);
    endcase
  endfunction

  task automatic runSingle(int pattern, int pct, int enPct, bit flipMode);
    int i = 0;
    while (active) begin
      if (flipMode && i == 2*R) modeCont = 1'b1; // R10
      stepCycle(($urandom % 100) < enPct, genBit(pattern, i, pct));
      i++;
    end
  endtask

  initial begin
    void'($urandom(32'd20240607));
    buildKernel();
    repeat (3) @(negedge clk);
    checkVal("R1", int'(validOut), 0);
    checkVal("R1", int'(resultWord), 0);
    rstN = 1'b1;
    @(negedge clk);
    checkVal("R1", int'(validOut), 0);

    // All ones, single-cycle: positive full scale
    curTag = "R5";
    startConv(0, 0, 0);
    runSingle(0, 0, 100, 0);
    checkVal("R5", int'($signed(resultWord)), 32767);
    // Bits after the word are ignored, result held
    curTag = "R6";
    for (int i = 0; i < 5*R; i++) stepCycle(1, ($urandom % 2) == 1);
    checkVal("R6", int'($signed(resultWord)), 32767);

    // All zeros; the bit offered with start is a 1 and must be dropped
    curTag = "R2";
    startConv(0, 1, 1);
    runSingle(1, 0, 100, 0);
    checkVal("R5", int'($signed(resultWord)), -32768);

    // Alternating with enable gaps
    curTag = "R3";
    startConv(0, 1, 0);
    runSingle(2, 0, 60, 0);

    // Biased random single conversions, one with a mode toggle mid-run
    curTag = "R4";
    for (int c = 0; c < 3; c++) begin
      startConv(0, 0, 0);
      runSingle(3, 20 + 30*c, 80, c == 1);
      modeCont = 1'b0;
    end
    curTag = "R10";
    for (int i = 0; i < 2*R; i++) stepCycle(1, 1);
    checkVal("R10", validCount, 1);

    // Abort and restart
    curTag = "R9";
    startConv(0, 0, 0);
    for (int i = 0; i < 3*R; i++) stepCycle(1, 1);
    startConv(0, 0, 0);
    runSingle(3, 30, 90, 0);

    // Continuous: words every period after settling
    curTag = "R7";
    startConv(1, 0, 0);
    for (int i = 0; i < 12*R; i++) stepCycle(($urandom % 100) < 85, (($urandom % 100) < 65));
    checkVal("R7", validCount, (nAcc / R) - 3);

    // Continuous from all-ones to all-zeros transition
    startConv(1, 0, 0);
    for (int i = 0; i < 5*R; i++) stepCycle(1, 1);
    for (int i = 0; i < 5*R; i++) stepCycle(1, 0);
    checkVal("R7", int'($signed(resultWord)), -32768);

    // Single after continuous: starts from cleared state
    curTag = "R2";
    startConv(0, 0, 0);
    runSingle(3, 75, 100, 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule